// File: doc/BRIEF.md
# Descriptor Ring Transaction Writer

This block turns one transaction of up to eight buffer segments into consecutive 128-bit transfer descriptors. It writes them, one per clock, into a circular ring held in local memory. Each segment supplies a 64-bit address, a 16-bit byte length and an 8-bit command opcode. The block keeps the ring write index itself. When a transaction runs past the last slot, the following descriptors go to slot zero.

Two static inputs describe the channel. The first says whether the channel carries commands. On a command channel each descriptor takes the opcode supplied for its segment. A non-zero opcode replaces the byte length in the length field. On a data channel the opcode is always the "none" value, zero. The second input gives the channel direction. Every descriptor on a channel that sends toward the device carries an interrupt-suppression flag.

When all descriptors are written, the block does three things. It pulses a completion strobe. It optionally pulses a doorbell. It publishes the new write index and the number of payload bytes in the transaction.

Top module: `desc_ring_writer`

## Requirements
- R1: While reset is held and after it releases, busy, reject, desc_we, done and doorbell are 0, and wr_index and byte_total are 0.
- R2: A commit with cmt_count above 8 produces a one-cycle reject pulse in the cycle after acceptance. It writes no descriptor, raises no done and leaves wr_index and byte_total unchanged.
- R3: A commit of N descriptors (1 to 8) is accepted only while the block is idle. Acceptance is followed, in the next cycle, by N consecutive cycles with desc_we and busy high. desc_slot runs wr_index, wr_index+1, ... modulo RING_DEPTH, so it wraps from the last slot to slot 0 in the middle of a transaction.
- R4: Descriptor bits [63:0] hold the address of segment k for the k-th written descriptor.
- R5: On a command channel with a non-zero opcode, bits [79:64] hold the opcode zero-extended and bits [87:80] hold the opcode. Otherwise bits [79:64] hold the segment byte length. Bits [87:80] hold the segment opcode on a command channel and 0 on a data channel.
- R6: The last flag, bit 88, and the interrupt-on-end flag, bit 90, are set on the final descriptor of a transaction only.
- R7: The interrupt-suppression bit, 89, equals cfg_toward_dev on every descriptor.
- R8: A commit with cmt_count 0 writes no descriptor. It gives a done pulse in the next cycle with no doorbell. It leaves wr_index unchanged and sets byte_total to 0.
- R9: doorbell pulses together with done, and only when cmt_ring_db was 1 at acceptance.
- R10: In the done cycle, wr_index is the old index plus N modulo RING_DEPTH. byte_total is the sum of the segment lengths whose descriptor length field carries a byte length. Both hold until the next done.
- R11: cmt_valid asserted while busy is ignored. It does not change the running transaction or start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cmd_chan | input | 1 | Channel carries command descriptors |
| cfg_toward_dev | input | 1 | Channel sends toward the device |
| cmt_valid | input | 1 | Commit request, taken when idle |
| cmt_count | input | CNT_W (4) | Number of segments in the transaction |
| cmt_ring_db | input | 1 | Ring doorbell when the commit finishes |
| cmt_addr | input | MAX_SEGS*64 | Segment addresses, segment k at [64k+63:64k] |
| cmt_len | input | MAX_SEGS*16 | Segment byte lengths |
| cmt_op | input | MAX_SEGS*8 | Segment command opcodes |
| busy | output | 1 | Descriptors being written |
| reject | output | 1 | Oversized commit refused |
| desc_we | output | 1 | Descriptor write strobe |
| desc_slot | output | IDX_W (4) | Ring slot of the descriptor |
| desc_data | output | 128 | Descriptor contents |
| done | output | 1 | Commit finished |
| doorbell | output | 1 | Doorbell pulse |
| wr_index | output | IDX_W (4) | Ring write index after the last commit |
| byte_total | output | BYTE_W (20) | Payload bytes of the last commit |

## Verification
The assertions assume a few things about the inputs. The channel configuration stays still while the block is busy. The segment fields are sampled only in the acceptance cycle. Reset is held long enough that every register is loaded before the first checked edge. The bench changes the configuration inputs only between transactions, when the block is idle. It drives the segment buses at the falling edge and keeps them stable across the acceptance edge. It holds reset for three cycles. It also raises cmt_valid on purpose in the middle of a transaction to show that such a request is dropped.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 16;
    localparam int OP_W     = 8;
    localparam int DESC_W   = 128;
    localparam int SEG_W    = ADDR_W + LEN_W + OP_W;
    localparam int MAX_SEGS = 8;

    localparam logic [OP_W-1:0] OP_NONE = '0;

    localparam int BIT_LAST = 88;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [OP_W-1:0]   op;
    } seg_t;

    typedef struct packed {
        logic [DESC_W-ADDR_W-LEN_W-OP_W-4:0] rsvd;
        logic              ieot;
        logic              bei;
        logic              last;
        logic [OP_W-1:0]   opcode;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } desc_t;

    function automatic logic len_is_bytes(seg_t s, logic cmd);
        return !(cmd && (s.op != OP_NONE));
    endfunction

    function automatic desc_t build_desc(seg_t s, logic cmd, logic toward, logic fin);
        desc_t d;
        d        = '0;
        d.addr   = s.addr;
        d.len    = len_is_bytes(s, cmd) ? s.len : {{(LEN_W-OP_W){1'b0}}, s.op};
        d.opcode = cmd ? s.op : OP_NONE;
        d.last   = fin;
        d.bei    = toward;
        d.ieot   = fin;
        return d;
    endfunction

endpackage

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] slot,
    output logic [IDX_W-1:0] slot_next
);

    logic [IDX_W-1:0] slot_q;

    // Power-of-two ring: natural overflow of the index gives the wrap.
    assign slot_next = slot_q + IDX_W'(1);
    assign slot      = slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (load) begin
            slot_q <= load_val;
        end else if (step) begin
            slot_q <= slot_next;
        end
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (slot_q == $past(slot_q) + IDX_W'(1))); // R3

endmodule

// File: rtl/desc_seg_fmt.sv
module desc_seg_fmt
    import desc_ring_pkg::*;
#(
    parameter int NSEG  = 8,
    parameter int SEL_W = 4
) (
    input  logic [NSEG*SEG_W-1:0] seg_flat,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  cmd_chan,
    input  logic                  toward,
    input  logic                  is_last,
    output desc_t                 desc_o,
    output logic [LEN_W-1:0]      bytes_o
);

    seg_t segs [NSEG];
    seg_t cur;

    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign segs[g] = seg_flat[g*SEG_W +: SEG_W];
    end

    always_comb begin
        cur = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (sel == SEL_W'(i)) cur = segs[i];
        end
    end

    assign desc_o  = build_desc(cur, cmd_chan, toward, is_last);
    assign bytes_o = len_is_bytes(cur, cmd_chan) ? cur.len : '0;

endmodule

// File: rtl/desc_ring_writer.sv
module desc_ring_writer
    import desc_ring_pkg::*;
#(
    parameter  int RING_DEPTH = 16,
    parameter  int NSEG       = desc_ring_pkg::MAX_SEGS,
    localparam int IDX_W      = $clog2(RING_DEPTH),
    localparam int CNT_W      = $clog2(NSEG) + 1,
    localparam int BYTE_W     = desc_ring_pkg::LEN_W + $clog2(NSEG) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_cmd_chan,
    input  logic                   cfg_toward_dev,
    input  logic                   cmt_valid,
    input  logic [CNT_W-1:0]       cmt_count,
    input  logic                   cmt_ring_db,
    input  logic [NSEG*64-1:0]     cmt_addr,
    input  logic [NSEG*16-1:0]     cmt_len,
    input  logic [NSEG*8-1:0]      cmt_op,
    output logic                   busy,
    output logic                   reject,
    output logic                   desc_we,
    output logic [IDX_W-1:0]       desc_slot,
    output logic [127:0]           desc_data,
    output logic                   done,
    output logic                   doorbell,
    output logic [IDX_W-1:0]       wr_index,
    output logic [BYTE_W-1:0]      byte_total
);

    wr_state_e              state_q;
    logic [CNT_W-1:0]       k_q, n_q;
    logic                   db_q, cmd_q, tow_q;
    logic [BYTE_W-1:0]      acc_q;
    logic                   done_q, db_out_q, rej_q;
    logic [IDX_W-1:0]       head_q;
    logic [BYTE_W-1:0]      bytes_q;
    logic [NSEG*SEG_W-1:0]  seg_in, seg_q;

    logic                   accept, writing, is_last;
    logic [IDX_W-1:0]       slot, slot_next;
    desc_t                  desc;
    logic [LEN_W-1:0]       seg_bytes;
    logic [BYTE_W-1:0]      acc_next;

    for (genvar g = 0; g < NSEG; g++) begin : g_pack
        assign seg_in[g*SEG_W +: SEG_W] = {cmt_addr[g*64 +: 64], cmt_len[g*16 +: 16], cmt_op[g*8 +: 8]};
    end

    assign accept   = cmt_valid && (state_q == ST_IDLE);
    assign writing  = (state_q == ST_WRITE);
    assign is_last  = (k_q == n_q - CNT_W'(1));
    assign acc_next = acc_q + BYTE_W'(seg_bytes);

    desc_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_val  (head_q),
        .step      (writing),
        .slot      (slot),
        .slot_next (slot_next)
    );

    desc_seg_fmt #(.NSEG(NSEG), .SEL_W(CNT_W)) u_fmt (
        .seg_flat (seg_q),
        .sel      (k_q),
        .cmd_chan (cmd_q),
        .toward   (tow_q),
        .is_last  (is_last),
        .desc_o   (desc),
        .bytes_o  (seg_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            k_q      <= '0;
            n_q      <= '0;
            db_q     <= 1'b0;
            cmd_q    <= 1'b0;
            tow_q    <= 1'b0;
            acc_q    <= '0;
            done_q   <= 1'b0;
            db_out_q <= 1'b0;
            rej_q    <= 1'b0;
            head_q   <= '0;
            bytes_q  <= '0;
            seg_q    <= '0;
        end else begin
            done_q   <= 1'b0;
            db_out_q <= 1'b0;
            rej_q    <= 1'b0;
            if (accept) begin
                if (cmt_count > CNT_W'(NSEG)) begin
                    rej_q <= 1'b1;
                end else if (cmt_count == '0) begin
                    done_q  <= 1'b1;
                    bytes_q <= '0;
                end else begin
                    state_q <= ST_WRITE;
                    k_q     <= '0;
                    n_q     <= cmt_count;
                    db_q    <= cmt_ring_db;
                    cmd_q   <= cfg_cmd_chan;
                    tow_q   <= cfg_toward_dev;
                    acc_q   <= '0;
                    seg_q   <= seg_in;
                end
            end else if (writing) begin
                acc_q <= acc_next;
                if (is_last) begin
                    state_q  <= ST_IDLE;
                    done_q   <= 1'b1;
                    db_out_q <= db_q;
                    head_q   <= slot_next;
                    bytes_q  <= acc_next;
                end else begin
                    k_q <= k_q + CNT_W'(1);
                end
            end
        end
    end

    assign busy       = writing;
    assign reject     = rej_q;
    assign desc_we    = writing;
    assign desc_slot  = slot;
    assign desc_data  = desc;
    assign done       = done_q;
    assign doorbell   = db_out_q;
    assign wr_index   = head_q;
    assign byte_total = bytes_q;

    AST_LAST_STOPS: assert property (@(posedge clk) disable iff (rst)
        (desc_we && desc_data[BIT_LAST]) |=> !desc_we); // R6

    AST_DB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> done); // R9

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        reject |-> (!desc_we && !done)); // R2

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(wr_index)); // R10

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && cmt_valid) |=> !reject); // R11

endmodule

// File: tb/desc_ring_writer_bench.sv
module desc_ring_writer_bench;

    localparam int DEPTH = 16;
    localparam int NS    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_cmd_chan = 1'b0;
    logic          cfg_toward_dev = 1'b0;
    logic          cmt_valid = 1'b0;
    logic [3:0]    cmt_count = '0;
    logic          cmt_ring_db = 1'b0;
    logic [NS*64-1:0] cmt_addr = '0;
    logic [NS*16-1:0] cmt_len = '0;
    logic [NS*8-1:0]  cmt_op = '0;

    logic          busy, reject, desc_we, done, doorbell;
    logic [3:0]    desc_slot, wr_index;
    logic [127:0]  desc_data;
    logic [19:0]   byte_total;

    int total = 0;
    int bad = 0;
    int wcount = 0;

    always #10 clk = ~clk;

    desc_ring_writer u_desc_ring_writer (
        .clk(clk), .rst(rst),
        .cfg_cmd_chan(cfg_cmd_chan), .cfg_toward_dev(cfg_toward_dev),
        .cmt_valid(cmt_valid), .cmt_count(cmt_count), .cmt_ring_db(cmt_ring_db),
        .cmt_addr(cmt_addr), .cmt_len(cmt_len), .cmt_op(cmt_op),
        .busy(busy), .reject(reject), .desc_we(desc_we), .desc_slot(desc_slot),
        .desc_data(desc_data), .done(done), .doorbell(doorbell),
        .wr_index(wr_index), .byte_total(byte_total)
    );

    typedef struct {
        bit          we;
        int          slot;
        bit [63:0]   addr;
        bit [15:0]   lenf;
        bit [7:0]    opf;
        bit          last;
        bit          bei;
        bit          done;
        bit          db;
        bit          rej;
        bit          upd;
        int          head;
        int          bytes;
    } ev_t;

    ev_t q[$];
    ev_t cur;
    int  m_head = 0;
    int  m_bytes = 0;

    function automatic ev_t idle_ev();
        ev_t e;
        e = '{default: 0};
        return e;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: each accepted commit becomes a list of future output cycles.
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = idle_ev();
            m_head = 0;
            m_bytes = 0;
        end else begin
            if (!cur.we && cmt_valid) begin
                int n;
                n = int'(cmt_count);
                if (n > NS) begin
                    ev_t e = idle_ev();
                    e.rej = 1;
                    q.push_back(e);
                end else if (n == 0) begin
                    ev_t e = idle_ev();
                    e.done = 1; e.upd = 1; e.head = m_head; e.bytes = 0;
                    q.push_back(e);
                end else begin
                    int s, sum;
                    s = m_head; sum = 0;
                    for (int i = 0; i < n; i++) begin
                        ev_t e = idle_ev();
                        bit [7:0] op;
                        bit [15:0] ln;
                        op = cmt_op[i*8 +: 8];
                        ln = cmt_len[i*16 +: 16];
                        e.we = 1;
                        e.slot = s;
                        e.addr = cmt_addr[i*64 +: 64];
                        if (cfg_cmd_chan && op != 0) e.lenf = {8'h00, op};
                        else begin e.lenf = ln; sum += int'(ln); end
                        e.opf = cfg_cmd_chan ? op : 8'h00;
                        e.last = (i == n-1);
                        e.bei = cfg_toward_dev;
                        q.push_back(e);
                        s = (s + 1) % DEPTH;
                    end
                    begin
                        ev_t e = idle_ev();
                        e.done = 1; e.db = cmt_ring_db; e.upd = 1; e.head = s; e.bytes = sum;
                        q.push_back(e);
                    end
                end
            end
            if (q.size() > 0) cur = q.pop_front();
            else cur = idle_ev();
            if (cur.upd) begin
                m_head = cur.head;
                m_bytes = cur.bytes;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (desc_we === 1'b1) wcount++;
            chk("R3 busy", 128'(busy), 128'(cur.we));
            chk("R3 desc_we", 128'(desc_we), 128'(cur.we));
            chk("R2 reject", 128'(reject), 128'(cur.rej));
            chk("R10 done", 128'(done), 128'(cur.done));
            chk("R9 doorbell", 128'(doorbell), 128'(cur.db));
            chk("R10 wr_index", 128'(wr_index), 128'(m_head));
            chk("R10 byte_total", 128'(byte_total), 128'(m_bytes));
            if (cur.we) begin
                chk("R3 slot", 128'(desc_slot), 128'(cur.slot));
                chk("R4 addr", 128'(desc_data[63:0]), 128'(cur.addr));
                chk("R5 len field", 128'(desc_data[79:64]), 128'(cur.lenf));
                chk("R5 opcode field", 128'(desc_data[87:80]), 128'(cur.opf));
                chk("R6 last", 128'(desc_data[88]), 128'(cur.last));
                chk("R7 bei", 128'(desc_data[89]), 128'(cur.bei));
                chk("R6 ieot", 128'(desc_data[90]), 128'(cur.last));
                chk("R4 reserved", 128'(desc_data[127:91]), 128'(0));
            end
        end
    end

    task automatic fill(int seed);
        for (int i = 0; i < NS; i++) begin
            cmt_addr[i*64 +: 64] = 64'h0000_1000_0000_0000 * 64'(seed + 1) + 64'(i * 64);
            cmt_len[i*16 +: 16]  = 16'(100 * (i + 1) + seed);
            cmt_op[i*8 +: 8]     = (i % 3 == 0) ? 8'h00 : 8'(seed * 16 + i);
        end
    endtask

    task automatic commit(int n, bit db, int seed);
        @(negedge clk);
        fill(seed);
        cmt_count = 4'(n);
        cmt_ring_db = db;
        cmt_valid = 1'b1;
        @(negedge clk);
        cmt_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wsave, hsave;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 busy", 128'(busy), 0);
        chk("R1 desc_we", 128'(desc_we), 0);
        chk("R1 done", 128'(done), 0);
        chk("R1 doorbell", 128'(doorbell), 0);
        chk("R1 reject", 128'(reject), 0);
        chk("R1 wr_index", 128'(wr_index), 0);
        chk("R1 byte_total", 128'(byte_total), 0);
        rst = 1'b0;

        cfg_cmd_chan = 1'b0; cfg_toward_dev = 1'b1;
        commit(3, 1'b1, 1);                        // data channel
        cfg_cmd_chan = 1'b1;
        commit(5, 1'b0, 2);                        // command opcodes, head 8
        cfg_cmd_chan = 1'b0; cfg_toward_dev = 1'b0;
        commit(6, 1'b1, 3);                        // head 14
        cfg_cmd_chan = 1'b1; cfg_toward_dev = 1'b1;
        commit(8, 1'b1, 4);                        // wraps mid transaction, R3
        chk("R3 wrap head", 128'(wr_index), 6);

        wsave = wcount; hsave = int'(wr_index);
        commit(9, 1'b1, 5);                        // R2
        commit(15, 1'b0, 6);                       // R2
        chk("R2 no writes", 128'(wcount), 128'(wsave));
        chk("R2 head kept", 128'(wr_index), 128'(hsave));

        commit(0, 1'b1, 7);                        // R8
        chk("R8 no writes", 128'(wcount), 128'(wsave));
        chk("R8 head kept", 128'(wr_index), 128'(hsave));
        chk("R8 bytes zero", 128'(byte_total), 0);

        // R11: request during a running transaction is dropped
        cfg_cmd_chan = 1'b0;
        @(negedge clk);
        fill(8);
        cmt_count = 4'd5; cmt_ring_db = 1'b0; cmt_valid = 1'b1;
        @(negedge clk);
        cmt_valid = 1'b0;
        @(negedge clk);
        cmt_count = 4'd2; cmt_ring_db = 1'b1; cmt_valid = 1'b1;
        repeat (2) @(negedge clk);
        cmt_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk("R11 only first commit written", 128'(wcount), 128'(wsave + 5));
        chk("R11 head", 128'(wr_index), 128'((hsave + 5) % DEPTH));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule